// File: doc/BRIEF.md
# Collision-Safe Retransmit FIFO

This block is a byte-wide transmit FIFO. It sits between a frame source and a half-duplex media transmitter. Each entry holds one byte and a frame-end flag. The transmitter reads bytes from the head of the FIFO one at a time.

In half-duplex operation, the FIFO holds back the first `WINDOW` bytes of every frame after they are read. If the transmitter reports a collision inside that window, the read side returns to the first byte of the frame and sends it again. The writer takes no part in this retry. When the window has passed, the held bytes are released and each later byte is released as it is read. If a collision arrives after the window, the rest of the frame is thrown away inside the FIFO and reading continues at the next frame. In full-duplex operation, every byte is released as soon as it is read.

The writer sees a free count. That count comes from a committed pointer, which marks everything not yet released, and not from the live read position. A write can therefore never overwrite a byte that might still be replayed.

The control path is a four-state machine:
- `S_IDLE`: the read side sits at a frame start.
- `S_HOLD`: a frame is being sent and is still inside the window.
- `S_STREAM`: the window has passed, or the link is full duplex.
- `S_DROP`: the rest of a frame is being discarded after a late collision.

The transitions are as follows:
- IDLE→HOLD: the first byte of a frame that has more than one byte is read in half duplex.
- IDLE→STREAM: the same first read happens in full duplex.
- IDLE→IDLE: a one-byte frame is read.
- HOLD→IDLE: a rewind arrives, or the frame ends inside the window.
- HOLD→STREAM: the `WINDOW`-th byte is read.
- HOLD→DROP and STREAM→DROP: an abort arrives.
- STREAM→IDLE: the last byte of the frame is read.
- DROP→IDLE: the frame-end byte is discarded.

The parameters have these limits:
- `DEPTH` must be a power of two and larger than `WINDOW`.
- `WINDOW` must be at least 2.
- `full_duplex` changes only while the read side sits at a frame start.

Top module: `retx_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid` is 0, `free_cnt` equals DEPTH and `wr_ready` is 1.
- R2: A byte presented with `wr_valid` while `wr_ready` is 1 is stored with its `wr_last` flag. Bytes are read in write order. The oldest unread byte appears on `rd_data`/`rd_last` with `rd_valid` = 1 in the cycle after its write.
- R3: `free_cnt` equals DEPTH minus the entries written and not yet released, and `wr_ready` is 1 exactly when `free_cnt` is nonzero. A write attempted while `free_cnt` is 0 is not stored.
- R4: In half duplex, bytes read from the current frame stay unreleased until the WINDOW-th byte of the frame is read. That read releases all bytes read so far, and each later read releases one more byte.
- R5: When the frame-end byte is read, every byte of that frame is released in the following cycle, whether or not the window was reached.
- R6: `tx_rewind` while the frame is inside the window moves the read side back to the frame's first byte. `free_cnt` does not change.
- R7: `tx_rewind` has no effect once the window has passed, at a frame start, or in full duplex. The head byte and `free_cnt` stay unchanged.
- R8: `tx_abort` during a frame discards the unread rest of that frame at one byte per cycle. Discarded bytes are never shown: `rd_valid` stays 0 while they are discarded. Each discarded byte is released as it is dropped, and reading resumes at the next frame's first byte. Priority is rewind, then abort, then read.
- R9: In full duplex, every byte read is released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_duplex | input | 1 | 1 = release each byte on read, 0 = collision window applies |
| wr_valid | input | 1 | Writer offers a byte |
| wr_data | input | DATA_W | Byte to store |
| wr_last | input | 1 | Byte ends its frame |
| wr_ready | output | 1 | At least one entry is free |
| free_cnt | output | $clog2(DEPTH+1) | Entries the writer may still fill |
| rd_valid | output | 1 | Head byte is available to the transmitter |
| rd_data | output | DATA_W | Head byte |
| rd_last | output | 1 | Head byte ends its frame |
| rd_en | input | 1 | Transmitter takes the head byte |
| tx_rewind | input | 1 | Early collision: replay the frame from its start |
| tx_abort | input | 1 | Late collision: discard the rest of the frame |

## Verification
The hardest case to reach is a late collision that arrives after the window has already released part of a frame. Hitting it requires a frame longer than the window, read past exactly the window boundary, then aborted while later bytes are still stored. The bench uses a small window of 4 in an 8-entry FIFO so each step can be driven directly. The stimulus table reads a six-byte frame through the boundary, aborts it, and follows the free count byte by byte through the discard. A second abort inside the window shows that the held bytes are released only when the discard moves past them. A fill to zero free entries follows, with reads that do not raise the free count until the window completes.

// File: rtl/retx_pkg.sv
package retx_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HOLD   = 2'd1,
        S_STREAM = 2'd2,
        S_DROP   = 2'd3
    } retx_state_e;

endpackage

// File: rtl/retx_store.sv
module retx_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int EW    = DATA_W + 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/retx_wside.sv
module retx_wside #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW:0]   cm_ptr,
    output logic          wr_ready,
    output logic          we,
    output logic [AW:0]   wr_ptr,
    output logic [CW-1:0] free_cnt
);

    logic [AW:0] used;

    assign used     = wr_ptr - cm_ptr;
    assign free_cnt = CW'(DEPTH) - CW'(used);
    assign wr_ready = (free_cnt != '0);
    assign we       = wr_valid && wr_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (we) begin
            wr_ptr <= wr_ptr + (AW+1)'(1);
        end
    end

endmodule

// File: rtl/retx_ctrl.sv
module retx_ctrl
    import retx_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int WINDOW = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(WINDOW + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        full_duplex,
    input  logic [AW:0] wr_ptr,
    input  logic        rd_en,
    input  logic        tx_rewind,
    input  logic        tx_abort,
    input  logic        head_last,
    output logic        rd_valid,
    output logic [AW:0] rd_ptr,
    output logic [AW:0] cm_ptr,
    output retx_state_e state
);

    localparam logic [SW-1:0] WIN_L = SW'(WINDOW);

    retx_state_e state_d;
    logic [AW:0] rd_d, cm_d, rd_inc;
    logic [SW-1:0] sent_q, sent_d, sent_inc;
    logic nonempty, pop, drop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            rd_ptr <= '0;
            cm_ptr <= '0;
            sent_q <= '0;
        end else begin
            state  <= state_d;
            rd_ptr <= rd_d;
            cm_ptr <= cm_d;
            sent_q <= sent_d;
        end
    end

    // outputs
    always_comb begin
        nonempty = (rd_ptr != wr_ptr);
        rd_valid = nonempty && (state != S_DROP);
        pop      = rd_valid && rd_en;
        drop     = nonempty && (state == S_DROP);
    end

    assign rd_inc   = rd_ptr + (AW+1)'(1);
    assign sent_inc = sent_q + SW'(1);

    // next state
    always_comb begin
        state_d = state;
        rd_d    = rd_ptr;
        cm_d    = cm_ptr;
        sent_d  = sent_q;
        unique case (state)
            S_IDLE: begin
                if (pop) begin
                    rd_d = rd_inc;
                    if (head_last || full_duplex) begin
                        cm_d = rd_inc;
                    end
                    if (head_last) begin
                        state_d = S_IDLE;
                    end else if (full_duplex) begin
                        state_d = S_STREAM;
                    end else begin
                        state_d = S_HOLD;
                        sent_d  = SW'(1);
                    end
                end
            end
            S_HOLD: begin
                if (tx_rewind && !full_duplex) begin
                    rd_d    = cm_ptr;
                    sent_d  = '0;
                    state_d = S_IDLE;
                end else if (tx_abort) begin
                    state_d = S_DROP;
                end else if (pop) begin
                    rd_d   = rd_inc;
                    sent_d = sent_inc;
                    if (head_last) begin
                        cm_d    = rd_inc;
                        state_d = S_IDLE;
                    end else if (full_duplex || sent_inc == WIN_L) begin
                        cm_d    = rd_inc;
                        state_d = S_STREAM;
                    end
                end
            end
            S_STREAM: begin
                if (tx_abort) begin
                    state_d = S_DROP;
                end else if (pop) begin
                    rd_d = rd_inc;
                    cm_d = rd_inc;
                    if (head_last) begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_DROP: begin
                if (drop) begin
                    rd_d = rd_inc;
                    cm_d = rd_inc;
                    if (head_last) begin
                        state_d = S_IDLE;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
    import retx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int WINDOW = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         full_duplex,
    input  logic                         wr_valid,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_last,
    output logic                         wr_ready,
    output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_last,
    input  logic                         rd_en,
    input  logic                         tx_rewind,
    input  logic                         tx_abort
);

    localparam int AW = $clog2(DEPTH);

    logic [AW:0]     wr_ptr, rd_ptr, cm_ptr;
    logic            we;
    logic [DATA_W:0] head;
    retx_state_e     fsm_state;

    retx_wside #(.DEPTH(DEPTH)) u_wside (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .cm_ptr   (cm_ptr),
        .wr_ready (wr_ready),
        .we       (we),
        .wr_ptr   (wr_ptr),
        .free_cnt (free_cnt)
    );

    retx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (wr_ptr[AW-1:0]),
        .wdata ({wr_last, wr_data}),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (head)
    );

    retx_ctrl #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_duplex (full_duplex),
        .wr_ptr      (wr_ptr),
        .rd_en       (rd_en),
        .tx_rewind   (tx_rewind),
        .tx_abort    (tx_abort),
        .head_last   (head[DATA_W]),
        .rd_valid    (rd_valid),
        .rd_ptr      (rd_ptr),
        .cm_ptr      (cm_ptr),
        .state       (fsm_state)
    );

    assign rd_data = head[DATA_W-1:0];
    assign rd_last = head[DATA_W];

endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk
    import retx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full_duplex,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [CW-1:0] free_cnt,
    input logic          rd_valid,
    input logic          rd_en,
    input logic          tx_rewind,
    input logic          tx_abort,
    input retx_state_e   fsm_state
);

    // R3
    free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CW'(DEPTH));

    // R3
    empty_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == CW'(DEPTH)) |-> !rd_valid);

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_HOLD && !(rd_valid && rd_en) && !(wr_valid && wr_ready))
        |=> free_cnt == $past(free_cnt));

    // R6
    rewind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_HOLD && tx_rewind && !full_duplex) |=> fsm_state == S_IDLE);

    // R7
    stream_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_STREAM && tx_rewind && !tx_abort) |=> fsm_state != S_HOLD);

    // R8
    drop_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_DROP) |-> !rd_valid);

    // R9
    fd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && rd_valid && rd_en && !(wr_valid && wr_ready))
        |=> free_cnt == $past(free_cnt) + CW'(1));

endmodule

bind retx_fifo retx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .free_cnt    (free_cnt),
    .rd_valid    (rd_valid),
    .rd_en       (rd_en),
    .tx_rewind   (tx_rewind),
    .tx_abort    (tx_abort),
    .fsm_state   (fsm_state)
);

// File: tb/retx_fifo_bench.sv
module retx_fifo_bench;

    localparam int DEPTH  = 8;
    localparam int WINDOW = 4;
    localparam int NV     = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_duplex = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       wr_ready;
    logic [3:0] free_cnt;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_last;
    logic       rd_en = 1'b0;
    logic       tx_rewind = 1'b0;
    logic       tx_abort = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    retx_fifo #(.DATA_W(8), .DEPTH(DEPTH), .WINDOW(WINDOW)) u_retx_fifo (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ready(wr_ready), .free_cnt(free_cnt),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_en(rd_en), .tx_rewind(tx_rewind), .tx_abort(tx_abort)
    );

    typedef struct packed {
        logic       wv;
        logic [7:0] wd;
        logic       wl;
        logic       re;
        logic       rw;
        logic       ab;
        logic       ev;
        logic [7:0] ed;
        logic       el;
        logic [3:0] ef;
        logic [3:0] rq;
    } vec_t;

    // wv wd wl re rw ab | ev ed el ef | req
    localparam vec_t TBL [NV] = '{
        '{1,'hA0,0,0,0,0, 0,'h00,0,8, 1},   // R1 empty start
        '{1,'hA1,0,0,0,0, 1,'hA0,0,7, 2},   // R2 show-ahead
        '{1,'hA2,0,0,0,0, 1,'hA0,0,6, 3},
        '{1,'hA3,0,0,0,0, 1,'hA0,0,5, 3},
        '{1,'hA4,0,0,0,0, 1,'hA0,0,4, 3},
        '{1,'hA5,1,0,0,0, 1,'hA0,0,3, 3},
        '{0,'h00,0,1,0,0, 1,'hA0,0,2, 4},   // R4 reads hold space
        '{0,'h00,0,1,0,0, 1,'hA1,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hA2,0,2, 4},
        '{0,'h00,0,0,1,0, 1,'hA3,0,2, 6},   // R6 early collision
        '{0,'h00,0,0,0,0, 1,'hA0,0,2, 6},   // R6 replay from start
        '{0,'h00,0,1,0,0, 1,'hA0,0,2, 6},
        '{0,'h00,0,1,0,0, 1,'hA1,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hA2,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hA3,0,2, 4},   // R4 window-th read
        '{0,'h00,0,1,0,0, 1,'hA4,0,6, 4},   // R4 bulk release
        '{0,'h00,0,0,1,0, 1,'hA5,1,7, 4},   // R7 rewind past window
        '{0,'h00,0,1,0,0, 1,'hA5,1,7, 7},   // R7 no effect
        '{0,'h00,0,0,0,0, 0,'h00,0,8, 5},   // R5
        '{1,'hB0,0,0,0,0, 0,'h00,0,8, 2},
        '{1,'hB1,0,0,0,0, 1,'hB0,0,7, 2},
        '{1,'hB2,0,0,0,0, 1,'hB0,0,6, 3},
        '{1,'hB3,0,0,0,0, 1,'hB0,0,5, 3},
        '{1,'hB4,0,0,0,0, 1,'hB0,0,4, 3},
        '{1,'hB5,1,0,0,0, 1,'hB0,0,3, 3},
        '{0,'h00,0,1,0,0, 1,'hB0,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hB1,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hB2,0,2, 4},
        '{0,'h00,0,1,0,0, 1,'hB3,0,2, 4},
        '{0,'h00,0,0,0,1, 1,'hB4,0,6, 8},   // R8 late collision
        '{0,'h00,0,0,0,0, 0,'h00,0,6, 8},   // R8 hidden discard
        '{0,'h00,0,0,0,0, 0,'h00,0,7, 8},
        '{0,'h00,0,0,0,0, 0,'h00,0,8, 8},
        '{1,'hC0,0,0,0,0, 0,'h00,0,8, 2},
        '{1,'hC1,0,0,0,0, 1,'hC0,0,7, 2},
        '{1,'hC2,1,0,0,0, 1,'hC0,0,6, 2},
        '{1,'hD0,1,0,0,0, 1,'hC0,0,5, 2},
        '{0,'h00,0,1,0,0, 1,'hC0,0,4, 4},
        '{0,'h00,0,0,0,1, 1,'hC1,0,4, 8},   // R8 abort inside window
        '{0,'h00,0,0,0,0, 0,'h00,0,4, 8},
        '{0,'h00,0,0,0,0, 0,'h00,0,6, 8},
        '{0,'h00,0,1,0,0, 1,'hD0,1,7, 8},   // R8 resumes at next frame
        '{0,'h00,0,0,0,0, 0,'h00,0,8, 5},
        '{1,'hE0,0,0,0,0, 0,'h00,0,8, 2},
        '{1,'hE1,1,0,0,0, 1,'hE0,0,7, 2},
        '{0,'h00,0,1,0,0, 1,'hE0,0,6, 4},
        '{0,'h00,0,1,0,0, 1,'hE1,1,6, 5},   // R5 short frame
        '{0,'h00,0,0,0,0, 0,'h00,0,8, 5}
    };

    task automatic chk(input int rq, input logic ev, input logic [7:0] ed,
                       input logic el, input logic [3:0] ef);
        n_tests++;
        if (rd_valid !== ev || free_cnt !== ef || wr_ready !== (ef != 0) ||
            (ev && (rd_data !== ed || rd_last !== el))) begin
            n_fail++;
            $display("FAIL R%0d: got valid=%b data=%h last=%b free=%0d ready=%b, exp valid=%b data=%h last=%b free=%0d",
                     rq, rd_valid, rd_data, rd_last, free_cnt, wr_ready, ev, ed, el, ef);
        end
    endtask

    task automatic tick(input logic wv, input logic [7:0] wd, input logic wl,
                        input logic re, input logic rw, input logic ab);
        @(negedge clk);
        wr_valid = wv; wr_data = wd; wr_last = wl;
        rd_en = re; tx_rewind = rw; tx_abort = ab;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(1, 0, 8'h00, 0, 4'd8);           // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 0, 8'h00, 0, 4'd8);           // R1 after release

        for (int i = 0; i < NV; i++) begin
            tick(TBL[i].wv, TBL[i].wd, TBL[i].wl, TBL[i].re, TBL[i].rw, TBL[i].ab);
            chk(int'(TBL[i].rq), TBL[i].ev, TBL[i].ed, TBL[i].el, TBL[i].ef);
        end

        // R3 fill to zero free, ninth write refused
        for (int k = 0; k < 9; k++) begin
            tick(1, 8'hF0 + 8'(k), (k == 7), 0, 0, 0);
            if (k == 8) chk(3, 1, 8'hF0, 0, 4'd0);
        end
        // R4 reads inside the window free nothing
        tick(0, 0, 0, 1, 0, 0); chk(3, 1, 8'hF0, 0, 4'd0);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF1, 0, 4'd0);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF2, 0, 4'd0);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF3, 0, 4'd0);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF4, 0, 4'd4);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF5, 0, 4'd5);
        tick(0, 0, 0, 1, 0, 0); chk(4, 1, 8'hF6, 0, 4'd6);
        tick(0, 0, 0, 1, 0, 0); chk(5, 1, 8'hF7, 1, 4'd7);
        // R3 refused byte never appears
        tick(0, 0, 0, 0, 0, 0); chk(3, 0, 8'h00, 0, 4'd8);

        // R9 full duplex
        full_duplex = 1'b1;
        tick(1, 8'h90, 0, 0, 0, 0); chk(9, 0, 8'h00, 0, 4'd8);
        tick(1, 8'h91, 0, 0, 0, 0); chk(9, 1, 8'h90, 0, 4'd7);
        tick(1, 8'h92, 1, 0, 0, 0); chk(9, 1, 8'h90, 0, 4'd6);
        tick(0, 0, 0, 1, 0, 0);     chk(9, 1, 8'h90, 0, 4'd5);
        tick(0, 0, 0, 0, 1, 0);     chk(9, 1, 8'h91, 0, 4'd6);
        tick(0, 0, 0, 0, 0, 0);     chk(7, 1, 8'h91, 0, 4'd6);   // R7 in full duplex
        tick(0, 0, 0, 1, 0, 0);     chk(9, 1, 8'h91, 0, 4'd6);
        tick(0, 0, 0, 1, 0, 0);     chk(9, 1, 8'h92, 1, 4'd7);
        tick(0, 0, 0, 0, 0, 0);     chk(9, 0, 8'h00, 0, 4'd8);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule